// File: doc/BRIEF.md
# Header-Directed Unit Router

This block sits between a small number of link ports and the local upper layer of a node. Each input port delivers 72-bit routing units through a valid/ready handshake. A unit is an 8-bit header on bits [71:64] followed by a 64-bit payload on bits [63:0]. The header names a destination node and a message type. When a unit is accepted, the router fixes its destination: the local upper layer, one of the outbound link ports, or nowhere. The unit then waits in a single-entry slot for its port until that output takes it.

The destination comes either from a direct match against the node's own identifier or from a routing table with one entry per destination ID. Software can rewrite the table through a one-entry-per-cycle write port while traffic flows. This lets traffic steer around a link that has failed. A unit that is already held keeps the choice it was given on acceptance. When more than one input slot targets the same output, a round-robin arbiter decides the order. A unit whose table entry is not usable is discarded, and a per-port error pulse reports it.

Top module: `rtr_fabric`

## Requirements
- R1: After reset, every output valid and every drop pulse is low. Every input ready is high. All table entries read as unusable.
- R2: The header is bits [71:64]. The destination ID is bits [71:67] and the message type is bits [66:64]. A unit whose destination ID equals `node_id` is delivered on the local port unchanged, whatever the table holds. The unit appears there in the cycle after acceptance.
- R3: For any other destination, a table entry with bit 2 set (usable) and target bits [1:0] below NPORTS sends the unit unchanged to that outbound link port, in the cycle after acceptance. The message type has no effect on the choice.
- R4: A usable table entry whose target equals NPORTS (2 with default parameters) sends the unit to the local port.
- R5: A table write changes the routing only of units accepted after the write's clock edge. A unit held at the time of the write leaves on the port chosen at its acceptance.
- R6: A unit whose entry is not usable (bit 2 clear, or target above NPORTS) produces no output. It raises `drop_err` for its input port for exactly one cycle, in the cycle after acceptance. It leaves the slot free.
- R7: While an output is valid and not ready, its data stays unchanged. An input whose slot is still occupied shows ready low.
- R8: Among slots that request the same output together, the grant goes to the next input after the one most recently served on that output. After reset, input 0 is first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 5 | Identifier of this node |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Destination ID of the entry to write |
| tbl_entry | input | 3 | Entry value: bit 2 usable, bits [1:0] target |
| in_valid | input | NPORTS | Per-port unit valid |
| in_ready | output | NPORTS | Per-port slot can accept |
| in_data | input | NPORTS*72 | Per-port unit, port p at [p*72 +: 72] |
| out_valid | output | NPORTS | Outbound link valid |
| out_ready | input | NPORTS | Outbound link ready |
| out_data | output | NPORTS*72 | Outbound unit, port p at [p*72 +: 72] |
| loc_valid | output | 1 | Local delivery valid |
| loc_ready | input | 1 | Local delivery ready |
| loc_data | output | 72 | Local delivery unit |
| drop_err | output | NPORTS | One-cycle pulse per input when a unit is discarded |

## Verification
The hardest case to reach is the round-robin order. Two slots must request one output in the same cycle, and the pointer must already rest on input 0, so that a fixed-priority arbiter would give a different answer. The bench first drains a single unit from input 0 onto that output. It then holds the output not ready and loads both inputs on the same edge. It also rewrites a table entry while a unit is stalled in its slot, which shows that the held routing choice survives the write.

// File: rtl/rtr_pkg.sv
`timescale 1ns/1ps
package rtr_pkg;
  localparam int HDR_W  = 8;
  localparam int PAY_W  = 64;
  localparam int UNIT_W = HDR_W + PAY_W;
  localparam int ID_W   = 5;
  localparam int TYPE_W = HDR_W - ID_W;
  localparam int NENT   = 1 << ID_W;

  // destination ID sits at the top of the header
  function automatic logic [ID_W-1:0] unit_dest(input logic [UNIT_W-1:0] u);
    return u[UNIT_W-1 -: ID_W];
  endfunction

  // first requester after 'last', wrapping; returns 'last' when none
  function automatic logic [7:0] rr_pick(input logic [15:0] req,
                                         input logic [7:0] last,
                                         input int n);
    logic [7:0] sel;
    logic found;
    sel = last;
    found = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      if (k <= n && !found) begin
        if (req[(int'(last) + k) % n]) begin
          sel = 8'((int'(last) + k) % n);
          found = 1'b1;
        end
      end
    end
    return sel;
  endfunction
endpackage

// File: rtl/rtr_table.sv
`timescale 1ns/1ps
module rtr_table
  import rtr_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int TW = 2
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ID_W-1:0]                   node_id,
  input  logic                              wr_en,
  input  logic [ID_W-1:0]                   wr_addr,
  input  logic [TW:0]                       wr_entry,
  input  logic [NPORTS-1:0][UNIT_W-1:0]     units,
  output logic [NPORTS-1:0]                 route_ok,
  output logic [NPORTS-1:0][TW-1:0]         route_tgt
);
  localparam logic [TW-1:0] LOCAL = TW'(NPORTS);

  logic [TW:0] tab [NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) tab[e] <= '0;
    end else if (wr_en) begin
      tab[wr_addr] <= wr_entry;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_look
    logic [ID_W-1:0] dest;
    logic [TW:0]     ent;
    always_comb begin
      dest = unit_dest(units[p]);
      ent  = tab[dest];
      if (dest == node_id) begin
        route_ok[p]  = 1'b1;
        route_tgt[p] = LOCAL;
      end else begin
        route_ok[p]  = ent[TW] && (ent[TW-1:0] <= LOCAL);
        route_tgt[p] = ent[TW-1:0];
      end
    end
  end
endmodule

// File: rtl/rtr_in_slot.sv
`timescale 1ns/1ps
module rtr_in_slot
  import rtr_pkg::*;
#(
  parameter int TW = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [UNIT_W-1:0] in_unit,
  input  logic              route_ok,
  input  logic [TW-1:0]     route_tgt,
  input  logic              leave,
  output logic              held,
  output logic [UNIT_W-1:0] held_unit,
  output logic [TW-1:0]     held_tgt,
  output logic              drop
);
  logic fire;
  assign in_ready = !held || leave;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_unit <= '0;
      held_tgt  <= '0;
      drop      <= 1'b0;
    end else begin
      drop <= fire && !route_ok;
      if (fire && route_ok) begin
        held      <= 1'b1;
        held_unit <= in_unit;
        held_tgt  <= route_tgt;
      end else if (leave) begin
        held <= 1'b0;
      end
    end
  end

  a_r7_leave_needs_unit: assert property (@(posedge clk) disable iff (!rst_n)
    leave |-> held);
  a_r5_decision_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !leave) |=> (held && $stable(held_unit) && $stable(held_tgt)));
  a_r6_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !route_ok) |=> drop);
endmodule

// File: rtl/rtr_rr_arb.sv
`timescale 1ns/1ps
module rtr_rr_arb
  import rtr_pkg::*;
#(
  parameter int N = 2,
  parameter int GW = 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ready,
  output logic          valid,
  output logic [GW-1:0] gidx,
  output logic [N-1:0]  gnt
);
  logic          busy_q;
  logic [GW-1:0] hold_q, ptr_q, pick;

  always_comb begin
    pick  = GW'(rr_pick(16'(req), 8'(ptr_q), N));
    gidx  = busy_q ? hold_q : pick;
    valid = |req;
    gnt   = '0;
    if (valid) gnt[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= '0;
      ptr_q  <= GW'(N - 1);
    end else begin
      busy_q <= valid && !ready;
      hold_q <= gidx;
      if (valid && ready) ptr_q <= gidx;
    end
  end

  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[gidx]);
  a_r7_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && gidx == $past(gidx)));
endmodule

// File: rtl/rtr_fabric.sv
`timescale 1ns/1ps
module rtr_fabric
  import rtr_pkg::*;
#(
  parameter int NPORTS = 2
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ID_W-1:0]            node_id,
  input  logic                       tbl_we,
  input  logic [ID_W-1:0]            tbl_addr,
  input  logic [2:0]                 tbl_entry,
  input  logic [NPORTS-1:0]          in_valid,
  output logic [NPORTS-1:0]          in_ready,
  input  logic [NPORTS*UNIT_W-1:0]   in_data,
  output logic [NPORTS-1:0]          out_valid,
  input  logic [NPORTS-1:0]          out_ready,
  output logic [NPORTS*UNIT_W-1:0]   out_data,
  output logic                       loc_valid,
  input  logic                       loc_ready,
  output logic [UNIT_W-1:0]          loc_data,
  output logic [NPORTS-1:0]          drop_err
);
  localparam int TW   = $clog2(NPORTS + 1);
  localparam int GW   = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int NOUT = NPORTS + 1;

  logic [NPORTS-1:0][UNIT_W-1:0] units, h_unit;
  logic [NPORTS-1:0][TW-1:0]     r_tgt, h_tgt;
  logic [NPORTS-1:0]             r_ok, held, leave;
  logic [NOUT-1:0][NPORTS-1:0]   req, gnt;
  logic [NOUT-1:0][GW-1:0]       gidx;
  logic [NOUT-1:0]               ovalid, ordy;
  logic [NOUT-1:0][UNIT_W-1:0]   odata;

  for (genvar p = 0; p < NPORTS; p++) begin : g_unpack
    assign units[p] = in_data[p*UNIT_W +: UNIT_W];
  end

  rtr_table #(.NPORTS(NPORTS), .TW(TW)) u_tab (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_entry(TW'(tbl_entry[1:0]) | {tbl_entry[2], {TW{1'b0}}}),
    .units(units), .route_ok(r_ok), .route_tgt(r_tgt)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_slot
    rtr_in_slot #(.TW(TW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid[p]), .in_ready(in_ready[p]), .in_unit(units[p]),
      .route_ok(r_ok[p]), .route_tgt(r_tgt[p]), .leave(leave[p]),
      .held(held[p]), .held_unit(h_unit[p]), .held_tgt(h_tgt[p]),
      .drop(drop_err[p])
    );
  end

  assign ordy = {loc_ready, out_ready};

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    for (genvar p = 0; p < NPORTS; p++) begin : g_req
      assign req[o][p] = held[p] && (h_tgt[p] == TW'(o));
    end
    rtr_rr_arb #(.N(NPORTS), .GW(GW)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req[o]), .ready(ordy[o]),
      .valid(ovalid[o]), .gidx(gidx[o]), .gnt(gnt[o])
    );
    assign odata[o] = h_unit[gidx[o]];
  end

  always_comb begin
    leave = '0;
    for (int o = 0; o < NOUT; o++)
      leave = leave | (gnt[o] & {NPORTS{ordy[o]}});
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_pack
    assign out_valid[p] = ovalid[p];
    assign out_data[p*UNIT_W +: UNIT_W] = odata[p];
  end
  assign loc_valid = ovalid[NPORTS];
  assign loc_data  = odata[NPORTS];

  a_r7_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !loc_ready) |=> (loc_valid && $stable(loc_data)));
  a_r6_drop_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_err[0] && !$past(held[0])) |-> !held[0]);
endmodule

// File: tb/sim_rtr_fabric.sv
`timescale 1ns/1ps
module sim_rtr_fabric;
  localparam int NP = 2;
  localparam int UW = 72;

  logic clk = 0;
  logic rst_n = 0;
  logic [4:0] node_id = 5'd4;
  logic tbl_we = 0;
  logic [4:0] tbl_addr = 0;
  logic [2:0] tbl_entry = 0;
  logic [NP-1:0] in_valid = 0, in_ready, out_valid, drop_err;
  logic [NP-1:0] out_ready = 0;
  logic [NP*UW-1:0] in_data = 0, out_data;
  logic loc_valid, loc_ready = 0;
  logic [UW-1:0] loc_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rtr_fabric #(.NPORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_entry(tbl_entry),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_data(loc_data),
    .drop_err(drop_err)
  );

  function automatic logic [UW-1:0] mk(input logic [4:0] d, input logic [2:0] t, input logic [63:0] pl);
    return {d, t, pl};
  endfunction

  task automatic chk(input string rq, input logic [UW-1:0] act, input logic [UW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [2:0] e);
    @(negedge clk);
    tbl_we = 1; tbl_addr = a; tbl_entry = e;
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  // load units on the masked ports in one edge; returns 1 ns after that edge
  task automatic push(input logic [NP-1:0] m, input logic [UW-1:0] ua, input logic [UW-1:0] ub);
    @(negedge clk);
    in_valid = m;
    in_data = {ub, ua};
    #1;
    chk("R7 slot free before push", UW'(in_ready & m), UW'(m));
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", UW'(out_valid), 0);
    chk("R1 loc_valid", UW'(loc_valid), 0);
    chk("R1 in_ready", UW'(in_ready), UW'(2'b11));
    chk("R1 drop_err", UW'(drop_err), 0);
  endtask

  task automatic t_local();
    logic [UW-1:0] u;
    u = mk(5'd4, 3'd6, 64'hA1A1_0000_1111_2222);
    out_ready = 2'b11; loc_ready = 1;
    push(2'b01, u, 0);
    chk("R2 local valid", UW'(loc_valid), 1);
    chk("R2 local data", loc_data, u);
    chk("R2 no link out", UW'(out_valid), 0);
    step();
    chk("R2 local gone", UW'(loc_valid), 0);
  endtask

  task automatic t_fwd();
    logic [UW-1:0] u, v;
    wr(5'd3, 3'b101);
    u = mk(5'd3, 3'd0, 64'hB0B0);
    v = mk(5'd3, 3'd7, 64'hB7B7);
    push(2'b01, u, 0);
    chk("R3 port1 valid", UW'(out_valid), UW'(2'b10));
    chk("R3 port1 data", out_data[UW +: UW], u);
    step();
    push(2'b10, 0, v);
    chk("R3 type ignored valid", UW'(out_valid), UW'(2'b10));
    chk("R3 type ignored data", out_data[UW +: UW], v);
    step();
  endtask

  task automatic t_tbl_local();
    logic [UW-1:0] u;
    wr(5'd7, 3'b110);
    u = mk(5'd7, 3'd1, 64'hC0DE);
    push(2'b10, 0, u);
    chk("R4 table local valid", UW'(loc_valid), 1);
    chk("R4 table local data", loc_data, u);
    chk("R4 no link out", UW'(out_valid), 0);
    step();
  endtask

  task automatic t_drop();
    push(2'b01, mk(5'd12, 3'd0, 64'hDEAD), 0);
    chk("R6 drop pulse unset entry", UW'(drop_err), UW'(2'b01));
    chk("R6 no output", UW'({loc_valid, out_valid}), 0);
    step();
    chk("R6 pulse ends", UW'(drop_err), 0);
    chk("R6 slot free", UW'(in_ready), UW'(2'b11));
    wr(5'd13, 3'b111);
    push(2'b10, 0, mk(5'd13, 3'd0, 64'hBEEF));
    chk("R6 drop pulse bad target", UW'(drop_err), UW'(2'b10));
    chk("R6 no output bad target", UW'({loc_valid, out_valid}), 0);
    step();
  endtask

  task automatic t_stall_rewrite();
    logic [UW-1:0] u, v;
    wr(5'd9, 3'b100);
    out_ready = 2'b00;
    u = mk(5'd9, 3'd2, 64'h5151);
    push(2'b01, u, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 held data", out_data[0 +: UW], u);
      chk("R7 slot busy", UW'(in_ready[0]), 0);
    end
    wr(5'd9, 3'b101);
    chk("R5 held unit stays on port0", UW'(out_valid), UW'(2'b01));
    chk("R5 held data", out_data[0 +: UW], u);
    v = mk(5'd9, 3'd2, 64'h6262);
    push(2'b10, 0, v);
    chk("R5 new unit to port1", UW'(out_valid), UW'(2'b11));
    chk("R5 new data", out_data[UW +: UW], v);
    @(negedge clk); out_ready = 2'b11;
    step();
    chk("R7 drained", UW'(out_valid), 0);
  endtask

  task automatic t_rr();
    logic [UW-1:0] a0, a1, b1;
    a0 = mk(5'd3, 3'd0, 64'h0A00);
    a1 = mk(5'd3, 3'd0, 64'h0A01);
    b1 = mk(5'd3, 3'd0, 64'h0B01);
    push(2'b01, a0, 0);
    chk("R8 single from input0", out_data[UW +: UW], a0);
    step();
    @(negedge clk); out_ready = 2'b00;
    push(2'b11, a1, b1);
    chk("R8 input1 after input0", out_data[UW +: UW], b1);
    step();
    chk("R8 grant held while stalled", out_data[UW +: UW], b1);
    @(negedge clk); out_ready = 2'b11;
    step();
    chk("R8 input0 next", out_data[UW +: UW], a1);
    step();
    chk("R8 all drained", UW'(out_valid), 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_local();
    t_fwd();
    t_tbl_local();
    t_drop();
    t_stall_rewrite();
    t_rr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule